// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers interrupt request lines and presents each of several processors with a 4-bit request level. Ordinary sources are numbered 1 to 15, and the level a processor sees is the source number itself, so a higher number always wins. A processor's trap type for a level is that number plus 0x10. One shared pending register records requests. One shared force register lets software raise a source without a hardware request. A clear register drops pending bits. Each processor has its own enable mask. A processor finishes handling a request by pulsing its acknowledge together with the level it took, and the controller then retires that request.

Extended sources 16 to 31 can be enabled by a parameter. All of them then share one ordinary line, whose number is also a parameter. When a processor acknowledges that line, the controller retires the highest extended source visible to that processor and records its number in that processor's identification register. A status word reports the processor count and whether broadcast is supported. Software reaches every register through a 32-bit word-addressed bus. Reads are combinational and change no state.

Top module: `mpic`

## Requirements
- R1: A 1 on `irq_in[n]` sets pending bit n at the next clock edge, for n in 1..15, and also for n in 16..31 when extended sources are enabled. `irq_in[0]` is ignored. Pending is read at word address 0.
- R2: Each processor's `cpu_level` carries the highest source number in 1..15 that is pending or forced and also enabled in that processor's mask. The value is 0 when there is none.
- R3: Each processor's mask sits at word address 16+k for processor k. Bit n set to 1 enables source n for that processor only, and bit n at 0 blocks it. The mask reads back as written, with bit 0 always 0 and bits 31:16 at 0 when extended sources are disabled.
- R4: A write to word address 2 clears every pending bit written as 1 and leaves every bit written as 0 unchanged. A request arriving on `irq_in` in the same cycle wins over the clear.
- R5: Word address 1 is the force register, bits 15:1. A write sets force bit n for every data bit n in 15:1 that is 1, and clears force bit n for every data bit n+16 that is 1. Setting wins over clearing.
- R6: A pulse on `cpu_ack[k]` with level L in 1..15 retires source L one edge later. The force bit is cleared if it is set; otherwise the pending bit is cleared. A level of 0 has no effect.
- R7: Word address 3 reads the processor count minus one in bits 31:28 and the broadcast parameter in bit 27. All other bits read 0.
- R8: With extended sources enabled, any pending source 16..31 enabled in processor k's mask raises line EXT_LINE for k. When k acknowledges EXT_LINE, the highest such source is cleared and its number is loaded into k's ID register at word address 32+k, in bits 4:0, where bit 4 set marks a valid number. If no extended source is visible, the ordinary line is retired and the ID register is loaded with 0.
- R9: Reads of unmapped addresses, including mask or ID slots of processors that do not exist, return 0. Reads never change state.
- R10: Reset, synchronous and active high, sets pending, force, all masks and all ID registers to 0, so every `cpu_level` is 0.
- R11: Writes to the pending address (word 0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt request lines, bit n is source n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cpu_level | output | NCPU*4 | Request level per processor, processor k in bits 4k+3:4k |
| cpu_ack | input | NCPU | Acknowledge pulse per processor |
| cpu_ack_level | input | NCPU*4 | Level being acknowledged, processor k in bits 4k+3:4k |

## Verification
On every cycle the assertions check the following. Any incoming request is latched as pending. A clear write leaves none of its bits pending unless the same bit is requested again. A force write leaves its bits set. A nonzero level always names a source that is both enabled and pending or forced for that processor, unless it is the shared extended line. The ID register holds either 0 or a number with its valid bit set. The bench scenarios show the rest: priority ordering between sources, one processor's mask not affecting another, forced-before-pending retirement on acknowledge, extended-source identification in descending order, the status word, unmapped reads, and the reset state.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int SRC_W  = 32;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 6;
    localparam int ID_W   = 5;

    localparam logic [ADDR_W-1:0] A_PEND      = 6'd0;
    localparam logic [ADDR_W-1:0] A_FORCE     = 6'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR     = 6'd2;
    localparam logic [ADDR_W-1:0] A_MPSTAT    = 6'd3;
    localparam int                A_MASK_BASE = 16;
    localparam int                A_ID_BASE   = 32;

    // acknowledge from one processor
    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
    } ack_t;

    // retirement request from one processor port
    typedef struct packed {
        logic [SRC_W-1:0] pend_clr;
        logic [15:0]      force_clr;
    } clr_req_t;

    // bits that can hold state, by extended enable
    function automatic logic [SRC_W-1:0] src_keep(input bit ext_en);
        return ext_en ? 32'hFFFF_FFFE : 32'h0000_FFFE;
    endfunction

endpackage

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mpic_cpu_port.sv
module mpic_cpu_port
    import mpic_pkg::*;
#(
    parameter bit EXT_EN   = 1'b1,
    parameter int EXT_LINE = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] pend,
    input  logic [15:0]      frc,
    input  logic             mask_we,
    input  logic [31:0]      wdata,
    input  ack_t             ack,
    output logic [LVL_W-1:0] level,
    output logic [SRC_W-1:0] mask_q,
    output logic [ID_W-1:0]  id_q,
    output clr_req_t         clr
);
    localparam logic [SRC_W-1:0] KEEP = src_keep(EXT_EN);

    logic [15:0]      ext_vis;
    logic [15:0]      req;
    logic [3:0]       ext_top;
    logic             ext_any;
    logic             req_any;
    logic             id_we;
    logic [ID_W-1:0]  id_nxt;

    assign ext_vis = EXT_EN ? (pend[31:16] & mask_q[31:16]) : 16'h0;

    always_comb begin
        req = (pend[15:0] | frc) & mask_q[15:0] & 16'hFFFE;
        if (EXT_EN && ext_any) req[EXT_LINE] = 1'b1;
    end

    mpic_prio_enc #(.W(16)) u_lvl (.vec(req),     .idx(level),   .any(req_any));
    mpic_prio_enc #(.W(16)) u_ext (.vec(ext_vis), .idx(ext_top), .any(ext_any));

    // acknowledge decode
    always_comb begin
        clr    = '0;
        id_we  = 1'b0;
        id_nxt = '0;
        if (ack.valid && ack.lvl != '0) begin
            if (EXT_EN && int'(ack.lvl) == EXT_LINE) begin
                id_we = 1'b1;
                if (ext_any) begin
                    id_nxt = {1'b1, ext_top};
                    clr.pend_clr[{1'b1, ext_top}] = 1'b1;
                end else if (frc[ack.lvl]) begin
                    clr.force_clr[ack.lvl] = 1'b1;
                end else begin
                    clr.pend_clr[ack.lvl] = 1'b1;
                end
            end else if (frc[ack.lvl]) begin
                clr.force_clr[ack.lvl] = 1'b1;
            end else begin
                clr.pend_clr[ack.lvl] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            id_q   <= '0;
        end else begin
            if (mask_we) mask_q <= wdata & KEEP;
            if (id_we)   id_q   <= id_nxt;
        end
    end

    logic unused_ok;
    assign unused_ok = req_any;
endmodule

// File: rtl/mpic.sv
module mpic
    import mpic_pkg::*;
#(
    parameter int NCPU     = 4,
    parameter bit EXT_EN   = 1'b1,
    parameter int EXT_LINE = 13,
    parameter bit BCAST    = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [31:0]            irq_in,
    input  logic                   bus_we,
    input  logic [5:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [NCPU*LVL_W-1:0]  cpu_level,
    input  logic [NCPU-1:0]        cpu_ack,
    input  logic [NCPU*LVL_W-1:0]  cpu_ack_level
);
    localparam logic [SRC_W-1:0] KEEP   = src_keep(EXT_EN);
    localparam logic [3:0]       NCPU_M = 4'(NCPU - 1);

    logic [SRC_W-1:0]      pend_q;
    logic [15:0]           force_q;
    logic [SRC_W-1:0]      mask_arr [NCPU];
    logic [ID_W-1:0]       id_arr   [NCPU];
    clr_req_t              clr_arr  [NCPU];
    logic [SRC_W-1:0]      pend_clr_all;
    logic [15:0]           force_clr_all;
    logic [SRC_W-1:0]      mask_all;
    logic [NCPU*SRC_W-1:0] mask_flat;
    logic [NCPU*ID_W-1:0]  id_flat;

    genvar k;
    generate
        for (k = 0; k < NCPU; k++) begin : g_cpu
            ack_t ack_k;
            assign ack_k.valid = cpu_ack[k];
            assign ack_k.lvl   = cpu_ack_level[k*LVL_W +: LVL_W];
            mpic_cpu_port #(.EXT_EN(EXT_EN), .EXT_LINE(EXT_LINE)) u_port (
                .clk     (clk),
                .rst     (rst),
                .pend    (pend_q),
                .frc     (force_q),
                .mask_we (bus_we && bus_addr == ADDR_W'(A_MASK_BASE + k)),
                .wdata   (bus_wdata),
                .ack     (ack_k),
                .level   (cpu_level[k*LVL_W +: LVL_W]),
                .mask_q  (mask_arr[k]),
                .id_q    (id_arr[k]),
                .clr     (clr_arr[k])
            );
            assign mask_flat[k*SRC_W +: SRC_W] = mask_arr[k];
            assign id_flat[k*ID_W +: ID_W]     = id_arr[k];
        end
    endgenerate

    always_comb begin
        pend_clr_all  = '0;
        force_clr_all = '0;
        for (int i = 0; i < NCPU; i++) begin
            pend_clr_all  = pend_clr_all  | clr_arr[i].pend_clr;
            force_clr_all = force_clr_all | clr_arr[i].force_clr;
        end
    end

    // shared pending and force state
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            force_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr_all
                       & ~((bus_we && bus_addr == A_CLEAR) ? bus_wdata : 32'h0))
                      | (irq_in & KEEP);
            if (bus_we && bus_addr == A_FORCE)
                force_q <= (force_q & ~force_clr_all & ~bus_wdata[31:16])
                           | (bus_wdata[15:0] & 16'hFFFE);
            else
                force_q <= force_q & ~force_clr_all;
        end
    end

    // read mux, no side effects
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PEND:   bus_rdata = pend_q;
            A_FORCE:  bus_rdata = {16'h0, force_q};
            A_MPSTAT: bus_rdata = {NCPU_M, BCAST, 27'h0};
            default:  bus_rdata = '0;
        endcase
        for (int i = 0; i < NCPU; i++) begin
            if (bus_addr == ADDR_W'(A_MASK_BASE + i)) bus_rdata = mask_arr[i];
            if (bus_addr == ADDR_W'(A_ID_BASE + i))   bus_rdata = {27'h0, id_arr[i]};
        end
    end

    assign mask_all = mask_arr[0];

    logic unused_ok;
    assign unused_ok = ^{mask_all, mask_flat, id_flat};
endmodule

// File: rtl/mpic_chk.sv
module mpic_chk
    import mpic_pkg::*;
#(
    parameter int NCPU     = 4,
    parameter bit EXT_EN   = 1'b1,
    parameter int EXT_LINE = 13
) (
    input logic                   clk,
    input logic                   rst,
    input logic [31:0]            irq_in,
    input logic                   bus_we,
    input logic [5:0]             bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NCPU*LVL_W-1:0]  cpu_level,
    input logic [SRC_W-1:0]       pend_q,
    input logic [15:0]            force_q,
    input logic [NCPU*SRC_W-1:0]  mask_flat,
    input logic [NCPU*ID_W-1:0]   id_flat
);
    localparam logic [SRC_W-1:0] KEEP = src_keep(EXT_EN);

    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (rst)
        ((irq_in & KEEP) != 0) |=> ((pend_q & $past(irq_in & KEEP)) == $past(irq_in & KEEP))); // R1

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLEAR) |=> ((pend_q & $past(bus_wdata & ~irq_in)) == 0)); // R4

    AST_FORCE_SETS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_FORCE)
        |=> ((force_q & $past(bus_wdata[15:0] & 16'hFFFE)) == $past(bus_wdata[15:0] & 16'hFFFE))); // R5

    genvar k;
    generate
        for (k = 0; k < NCPU; k++) begin : g_chk
            logic [3:0]  lv;
            logic [31:0] mk;
            logic [4:0]  idv;
            logic        ordinary;
            assign lv       = cpu_level[k*LVL_W +: LVL_W];
            assign mk       = mask_flat[k*SRC_W +: SRC_W];
            assign idv      = id_flat[k*ID_W +: ID_W];
            assign ordinary = (lv != 0) && !(EXT_EN && int'(lv) == EXT_LINE);

            AST_LVL_ENABLED: assert property (@(posedge clk) disable iff (rst)
                ordinary |-> mk[lv]); // R3

            AST_LVL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
                ordinary |-> (pend_q[lv] || force_q[lv])); // R2

            AST_ID_VALID: assert property (@(posedge clk) disable iff (rst)
                (idv != 0) |-> idv[4]); // R8
        end
    endgenerate
endmodule

bind mpic mpic_chk #(.NCPU(NCPU), .EXT_EN(EXT_EN), .EXT_LINE(EXT_LINE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cpu_level (cpu_level),
    .pend_q    (pend_q),
    .force_q   (force_q),
    .mask_flat (mask_flat),
    .id_flat   (id_flat)
);

// File: tb/sim_mpic.sv
module sim_mpic;
    localparam int NCPU = 4;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_IRQ = 3'd2;
    localparam logic [2:0] OP_ACK = 3'd3;
    localparam logic [2:0] OP_LVL = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  arg;   // address or processor index
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t VEC [NV] = '{
        '{OP_RD,  6'd3,  32'h0,          32'h3800_0000, 4'd7},  // R7 status
        '{OP_RD,  6'd0,  32'h0,          32'h0,         4'd10}, // R10
        '{OP_LVL, 6'd0,  32'h0,          32'h0,         4'd10}, // R10
        '{OP_WR,  6'd16, 32'h0000_00A0,  32'h0,         4'd3},  // R3 mask0 = {5,7}
        '{OP_IRQ, 6'd0,  32'h0000_0020,  32'h0,         4'd1},  // R1
        '{OP_RD,  6'd0,  32'h0,          32'h0000_0020, 4'd1},  // R1
        '{OP_LVL, 6'd0,  32'h0,          32'd5,         4'd2},  // R2
        '{OP_LVL, 6'd1,  32'h0,          32'd0,         4'd3},  // R3 cpu1 masked
        '{OP_IRQ, 6'd0,  32'h0000_0080,  32'h0,         4'd1},  // R1
        '{OP_LVL, 6'd0,  32'h0,          32'd7,         4'd2},  // R2 priority
        '{OP_WR,  6'd2,  32'h0000_0080,  32'h0,         4'd4},  // R4 clear 7
        '{OP_RD,  6'd0,  32'h0,          32'h0000_0020, 4'd4},  // R4
        '{OP_WR,  6'd1,  32'h0000_0080,  32'h0,         4'd5},  // R5 force 7
        '{OP_RD,  6'd1,  32'h0,          32'h0000_0080, 4'd5},  // R5
        '{OP_LVL, 6'd0,  32'h0,          32'd7,         4'd5},  // R5
        '{OP_ACK, 6'd0,  32'd7,          32'h0,         4'd6},  // R6
        '{OP_RD,  6'd1,  32'h0,          32'h0,         4'd6},  // R6
        '{OP_RD,  6'd0,  32'h0,          32'h0000_0020, 4'd6},  // R6
        '{OP_ACK, 6'd0,  32'd5,          32'h0,         4'd6},  // R6
        '{OP_RD,  6'd0,  32'h0,          32'h0,         4'd6},  // R6
        '{OP_LVL, 6'd0,  32'h0,          32'd0,         4'd6},  // R6
        '{OP_WR,  6'd17, 32'h0009_0000,  32'h0,         4'd8},  // R8 mask1 = {16,19}
        '{OP_RD,  6'd17, 32'h0,          32'h0009_0000, 4'd9},  // R9
        '{OP_IRQ, 6'd0,  32'h0009_0000,  32'h0,         4'd8},  // R8
        '{OP_LVL, 6'd1,  32'h0,          32'd13,        4'd8},  // R8
        '{OP_LVL, 6'd0,  32'h0,          32'd0,         4'd3},  // R3
        '{OP_ACK, 6'd1,  32'd13,         32'h0,         4'd8},  // R8
        '{OP_RD,  6'd33, 32'h0,          32'h0000_0013, 4'd8},  // R8 id 19
        '{OP_RD,  6'd0,  32'h0,          32'h0001_0000, 4'd8},  // R8
        '{OP_ACK, 6'd1,  32'd13,         32'h0,         4'd8},  // R8
        '{OP_RD,  6'd33, 32'h0,          32'h0000_0010, 4'd8},  // R8 id 16
        '{OP_LVL, 6'd1,  32'h0,          32'd0,         4'd8},  // R8
        '{OP_WR,  6'd1,  32'h0000_0002,  32'h0,         4'd5},  // R5
        '{OP_RD,  6'd1,  32'h0,          32'h0000_0002, 4'd5},  // R5
        '{OP_WR,  6'd1,  32'h0002_0000,  32'h0,         4'd5},  // R5 upper clears
        '{OP_RD,  6'd1,  32'h0,          32'h0,         4'd5},  // R5
        '{OP_WR,  6'd0,  32'hFFFF_FFFF,  32'h0,         4'd11}, // R11
        '{OP_RD,  6'd0,  32'h0,          32'h0,         4'd11}, // R11
        '{OP_WR,  6'd19, 32'h0000_8000,  32'h0,         4'd3},  // R3 mask3
        '{OP_WR,  6'd1,  32'h0000_8000,  32'h0,         4'd5},  // R5
        '{OP_LVL, 6'd3,  32'h0,          32'd15,        4'd2},  // R2 top source
        '{OP_ACK, 6'd3,  32'd0,          32'h0,         4'd6},  // R6 level 0
        '{OP_RD,  6'd1,  32'h0,          32'h0000_8000, 4'd6},  // R6
        '{OP_IRQ, 6'd0,  32'h0000_0001,  32'h0,         4'd1},  // R1 bit 0
        '{OP_RD,  6'd0,  32'h0,          32'h0,         4'd1},  // R1
        '{OP_RD,  6'd40, 32'h0,          32'h0,         4'd9},  // R9 unmapped
        '{OP_ACK, 6'd3,  32'd15,         32'h0,         4'd6},  // R6
        '{OP_RD,  6'd1,  32'h0,          32'h0,         4'd6}   // R6
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [31:0]         irq_in = '0;
    logic                bus_we = 1'b0;
    logic [5:0]          bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NCPU*4-1:0]   cpu_level;
    logic [NCPU-1:0]     cpu_ack = '0;
    logic [NCPU*4-1:0]   cpu_ack_level = '0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mpic #(.NCPU(NCPU), .EXT_EN(1'b1), .EXT_LINE(13), .BCAST(1'b1)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_level(cpu_level), .cpu_ack(cpu_ack), .cpu_ack_level(cpu_ack_level)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR: bus_write(VEC[i].arg, VEC[i].data);
                OP_RD: begin
                    bus_read(VEC[i].arg, rd);
                    check(int'(VEC[i].req), rd, VEC[i].exp);
                end
                OP_IRQ: begin
                    @(negedge clk); irq_in = VEC[i].data;
                    @(negedge clk); irq_in = '0;
                end
                OP_ACK: begin
                    @(negedge clk);
                    cpu_ack[VEC[i].arg] = 1'b1;
                    cpu_ack_level[VEC[i].arg*4 +: 4] = VEC[i].data[3:0];
                    @(negedge clk);
                    cpu_ack = '0;
                end
                default: begin
                    @(negedge clk);
                    #1 check(int'(VEC[i].req), {28'h0, cpu_level[VEC[i].arg*4 +: 4]}, VEC[i].exp);
                end
            endcase
        end

        // R4: a request on the same cycle as its clear wins
        @(negedge clk);
        irq_in = 32'h8; bus_we = 1'b1; bus_addr = 6'd2; bus_wdata = 32'h8;
        @(negedge clk);
        irq_in = '0; bus_we = 1'b0;
        bus_read(6'd0, rd);
        check(4, rd, 32'h8);

        // R10: reset clears state set up beforehand
        bus_write(6'd16, 32'hFFFF_FFFF);
        @(negedge clk); #1 check(10, {28'h0, cpu_level[3:0]}, 32'd3);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_read(6'd0, rd);  check(10, rd, 32'h0);
        bus_read(6'd16, rd); check(10, rd, 32'h0);
        bus_read(6'd33, rd); check(10, rd, 32'h0);
        #1 check(10, {16'h0, cpu_level}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired before all requirements were checked");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule